// File: doc/BRIEF.md
# Global command and status handshake unit

This unit sits between the register write path and the stub engines of an address and interrupt remapping block. It decodes software writes into one-shot operation requests and stored enable levels. It also keeps the six read-only status bits that software polls to learn when an operation has finished or when an enable has taken effect.

Three operations are one-shot: loading the fault-log pointer, flushing the write buffer, and loading the interrupt remap table pointer. Writing 1 to one of their command bits sends a single-cycle request to the matching engine, and the engine replies with a single-cycle done pulse. The two pointer loads use one polarity: status drops on the command and rises on completion. The flush uses the opposite polarity: status rises on the command and falls on completion.

Three enables are levels: advanced fault logging, queued invalidation and interrupt remapping. Each is driven to its engine as soon as it is written. Its status bit copies the driven level only when that engine acknowledges. Parameters remove the fault-log and flush features. When a feature is removed, its status bits read 0 and it issues no requests.

Top module: `gcsr_unit`

## Requirements
- R1: After reset all six status bits, all three request outputs and all three enable outputs are 0.
- R2: The status word places the bits as follows: bit 29 is fault-log pointer loaded, bit 28 is advanced fault logging on, bit 27 is flush in progress, bit 26 is queued invalidation on, bit 25 is interrupt remapping on, and bit 24 is table pointer loaded. Every other bit reads 0.
- R3: A write with bit 29 or bit 24 set, for a pointer load that is not pending, clears that status bit on the next cycle and raises that operation's request for that cycle.
- R4: A done pulse for a pending pointer load sets its status bit on the next cycle.
- R5: A write with bit 27 set, when no flush is pending, sets bit 27 of the status word and raises the flush request on the next cycle. A done pulse for that flush clears bit 27 on the next cycle.
- R6: Write bits 28, 26 and 25 drive en_cmd_o[2], en_cmd_o[1] and en_cmd_o[0] from the cycle after the write. The matching status bit takes the en_cmd_o value only in the cycle after the matching en_ack_i bit is high. Until then the status bit holds its old value.
- R7: Command bits are not stored. A request lasts one cycle per accepted command, and a write with a command bit at 0 starts nothing.
- R8: A command for an operation that is still pending produces no request and leaves that operation's status bit unchanged.
- R9: When a done pulse and a new command for the same operation arrive in the same cycle, the command wins. A new request is issued, and the status bit shows the in-progress value.
- R10: A done pulse for an operation that is not pending has no effect.
- R11: With HAS_ADV_FLOG = 0, bits 29 and 28 stay 0, flog_req_o stays 0 and en_cmd_o[2] stays 0. With NEEDS_WBF = 0, bit 27 stays 0 and flush_req_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Write data holding the command and enable bits |
| status_o | output | DATA_W | Read-back status word |
| flog_req_o | output | 1 | Fault-log pointer load request pulse |
| flog_done_i | input | 1 | Fault-log pointer load done pulse |
| flush_req_o | output | 1 | Write buffer flush request pulse |
| flush_done_i | input | 1 | Write buffer flush done pulse |
| tptr_req_o | output | 1 | Table pointer load request pulse |
| tptr_done_i | input | 1 | Table pointer load done pulse |
| en_cmd_o | output | 3 | Commanded enables: [2] advanced fault logging, [1] queued invalidation, [0] interrupt remapping |
| en_ack_i | input | 3 | Per-enable acknowledge from the engines, same bit order |

## Verification
The hardest case to reach is the collision. A done pulse and a fresh command must hit the same operation in one cycle, and the pending state has to exist first. The stimulus table first issues a flush and re-issues it while it is still pending, which must be ignored. It then presents the done pulse and a new flush write together, and checks that a second request appears while the status stays set. A later row completes a table pointer load in the same cycle that a fault-log pointer load starts, so both polarities change in one cycle. A second instance with both features removed receives the same stimulus.

// File: rtl/gcsr_pkg.sv
package gcsr_pkg;
   localparam int STAT_LSB  = 24;
   localparam int STAT_BITS = 6;
   // offsets relative to STAT_LSB; the layout is what software decodes
   localparam int OFS_FLOG  = 5;
   localparam int OFS_AFL   = 4;
   localparam int OFS_WBF   = 3;
   localparam int OFS_QIE   = 2;
   localparam int OFS_IRE   = 1;
   localparam int OFS_TPTR  = 0;
   localparam int N_EN      = 3;

   typedef struct packed {
      logic flog;
      logic afl;
      logic wbf;
      logic qie;
      logic ire;
      logic tptr;
   } gcsr_stat_t;
endpackage

// File: rtl/gcsr_op_track.sv
module gcsr_op_track #(
   parameter bit SET_ON_CMD = 1'b0,
   parameter bit SUPPORTED  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_i,
   input  logic done_i,
   output logic req_o,
   output logic stat_o
);
   generate
      if (SUPPORTED) begin : g_live
         logic pend_q, stat_q, req_q;
         logic accept;

         // a done in the same cycle frees the slot, so the command wins
         assign accept = cmd_i && (!pend_q || done_i);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               stat_q <= 1'b0;
               req_q  <= 1'b0;
            end else begin
               req_q <= accept;
               if (accept) begin
                  pend_q <= 1'b1;
                  stat_q <= SET_ON_CMD;
               end else if (done_i && pend_q) begin
                  pend_q <= 1'b0;
                  stat_q <= !SET_ON_CMD;
               end
            end
         end

         assign req_o  = req_q;
         assign stat_o = stat_q;

         assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i && !pend_q) |=> (req_o && stat_o == SET_ON_CMD));
         assert_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && pend_q && !cmd_i) |=> (stat_o == !SET_ON_CMD && !req_o));
         assert_no_cmd_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !cmd_i |=> !req_o);
         assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i && pend_q && !done_i) |=> (!req_o && $stable(stat_o)));
         assert_cmd_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i && done_i && pend_q) |=> (req_o && stat_o == SET_ON_CMD));
         assert_stray_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && !pend_q && !cmd_i) |=> $stable(stat_o));
      end else begin : g_absent
         wire unused_in = ^{clk, rst_n, cmd_i, done_i};
         assign req_o  = 1'b0;
         assign stat_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/gcsr_en_mirror.sv
module gcsr_en_mirror #(
   parameter int           N         = 3,
   parameter logic [N-1:0] LIVE_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [N-1:0] wr_bits_i,
   input  logic [N-1:0] ack_i,
   output logic [N-1:0] en_o,
   output logic [N-1:0] stat_o
);
   if (N < 1) begin : g_bad_n
      $error("gcsr_en_mirror: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (LIVE_MASK[i]) begin : g_live
         logic en_q, st_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q <= 1'b0;
               st_q <= 1'b0;
            end else begin
               if (wr_en_i) en_q <= wr_bits_i[i];
               if (ack_i[i]) st_q <= en_q;
            end
         end
         assign en_o[i]   = en_q;
         assign stat_o[i] = st_q;

         assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !ack_i[i] |=> $stable(stat_o[i]));
         assert_copy_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[i] && !wr_en_i) |=> (stat_o[i] == en_o[i]));
      end else begin : g_dead
         wire unused_b = ^{wr_bits_i[i], ack_i[i]};
         assign en_o[i]   = 1'b0;
         assign stat_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/gcsr_unit.sv
module gcsr_unit
   import gcsr_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit HAS_ADV_FLOG = 1'b1,
   parameter bit NEEDS_WBF    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] status_o,
   output logic              flog_req_o,
   input  logic              flog_done_i,
   output logic              flush_req_o,
   input  logic              flush_done_i,
   output logic              tptr_req_o,
   input  logic              tptr_done_i,
   output logic [N_EN-1:0]   en_cmd_o,
   input  logic [N_EN-1:0]   en_ack_i
);
   localparam int STAT_MSB = STAT_LSB + STAT_BITS - 1;
   localparam logic [N_EN-1:0] EN_LIVE = {HAS_ADV_FLOG, 1'b1, 1'b1};

   if (DATA_W <= STAT_MSB) begin : g_bad_width
      $error("gcsr_unit: DATA_W too narrow for the status field");
   end

   gcsr_stat_t           wd, st;
   logic [N_EN-1:0]      en_stat;

   assign wd = gcsr_stat_t'(wr_data_i[STAT_MSB:STAT_LSB]);

   gcsr_op_track #(.SET_ON_CMD(1'b0), .SUPPORTED(HAS_ADV_FLOG)) u_flog (
      .clk(clk), .rst_n(rst_n), .cmd_i(wr_en_i && wd.flog),
      .done_i(flog_done_i), .req_o(flog_req_o), .stat_o(st.flog));

   gcsr_op_track #(.SET_ON_CMD(1'b1), .SUPPORTED(NEEDS_WBF)) u_flush (
      .clk(clk), .rst_n(rst_n), .cmd_i(wr_en_i && wd.wbf),
      .done_i(flush_done_i), .req_o(flush_req_o), .stat_o(st.wbf));

   gcsr_op_track #(.SET_ON_CMD(1'b0), .SUPPORTED(1'b1)) u_tptr (
      .clk(clk), .rst_n(rst_n), .cmd_i(wr_en_i && wd.tptr),
      .done_i(tptr_done_i), .req_o(tptr_req_o), .stat_o(st.tptr));

   gcsr_en_mirror #(.N(N_EN), .LIVE_MASK(EN_LIVE)) u_en (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i),
      .wr_bits_i({wd.afl, wd.qie, wd.ire}), .ack_i(en_ack_i),
      .en_o(en_cmd_o), .stat_o(en_stat));

   assign st.afl = en_stat[2];
   assign st.qie = en_stat[1];
   assign st.ire = en_stat[0];

   always_comb begin
      status_o = '0;
      status_o[STAT_MSB:STAT_LSB] = st;
   end

   wire unused_wd = ^{wr_data_i};

   assert_en_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(en_cmd_o));
   assert_one_status_per_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && !flush_done_i) |=> !($rose(status_o[STAT_LSB+OFS_WBF])));

   if (!HAS_ADV_FLOG) begin : g_chk_noflog
      assert_flog_absent_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (status_o[STAT_LSB+OFS_FLOG] == 1'b0) && (status_o[STAT_LSB+OFS_AFL] == 1'b0)
         && !flog_req_o && !en_cmd_o[2]);
   end
   if (!NEEDS_WBF) begin : g_chk_nowbf
      assert_wbf_absent_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (status_o[STAT_LSB+OFS_WBF] == 1'b0) && !flush_req_o);
   end
endmodule

// File: tb/gcsr_unit_tb.sv
module gcsr_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [2:0]  done = '0;   // [2] flog, [1] flush, [0] tptr
   logic [2:0]  ack = '0;    // [2] afl, [1] qi, [0] ir
   logic [31:0] stat, stat_l;
   logic        fq, wq, tq, fq_l, wq_l, tq_l;
   logic [2:0]  en, en_l;
   int          checks = 0;
   int          fails = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   gcsr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .status_o(stat), .flog_req_o(fq), .flog_done_i(done[2]),
      .flush_req_o(wq), .flush_done_i(done[1]), .tptr_req_o(tq),
      .tptr_done_i(done[0]), .en_cmd_o(en), .en_ack_i(ack));

   gcsr_unit #(.HAS_ADV_FLOG(1'b0), .NEEDS_WBF(1'b0)) u_lite (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .status_o(stat_l), .flog_req_o(fq_l), .flog_done_i(done[2]),
      .flush_req_o(wq_l), .flush_done_i(done[1]), .tptr_req_o(tq_l),
      .tptr_done_i(done[0]), .en_cmd_o(en_l), .en_ack_i(ack));

   typedef struct packed {
      logic       we;
      logic [5:0] wd;   // flog afl wbf qie ire tptr
      logic [2:0] dn;
      logic [2:0] ak;
      logic [5:0] es;
      logic [2:0] er;   // flog flush tptr
   } vec_t;

   localparam int NV = 20;
   // rows: 2 R3, 3 R7, 4-5 R4, 6-7 R5, 8 R8, 9 R9, 10 R5, 11 R10,
   // 12-16 R6/R7, 17 R3, 18 R8, 19 R9/R4/R3, 20 R4
   localparam vec_t VECS [NV] = '{
      '{1'b0, 6'b000000, 3'b000, 3'b000, 6'b000000, 3'b000},
      '{1'b1, 6'b100001, 3'b000, 3'b000, 6'b000000, 3'b101},
      '{1'b0, 6'b000000, 3'b000, 3'b000, 6'b000000, 3'b000},
      '{1'b0, 6'b000000, 3'b100, 3'b000, 6'b100000, 3'b000},
      '{1'b0, 6'b000000, 3'b001, 3'b000, 6'b100001, 3'b000},
      '{1'b1, 6'b001000, 3'b000, 3'b000, 6'b101001, 3'b010},
      '{1'b0, 6'b000000, 3'b000, 3'b000, 6'b101001, 3'b000},
      '{1'b1, 6'b001000, 3'b000, 3'b000, 6'b101001, 3'b000},
      '{1'b1, 6'b001000, 3'b010, 3'b000, 6'b101001, 3'b010},
      '{1'b0, 6'b000000, 3'b010, 3'b000, 6'b100001, 3'b000},
      '{1'b0, 6'b000000, 3'b010, 3'b000, 6'b100001, 3'b000},
      '{1'b1, 6'b010110, 3'b000, 3'b000, 6'b100001, 3'b000},
      '{1'b0, 6'b000000, 3'b000, 3'b010, 6'b100101, 3'b000},
      '{1'b0, 6'b000000, 3'b000, 3'b101, 6'b110111, 3'b000},
      '{1'b1, 6'b000000, 3'b000, 3'b000, 6'b110111, 3'b000},
      '{1'b0, 6'b000000, 3'b000, 3'b111, 6'b100001, 3'b000},
      '{1'b1, 6'b000001, 3'b000, 3'b000, 6'b100000, 3'b001},
      '{1'b1, 6'b000001, 3'b000, 3'b000, 6'b100000, 3'b000},
      '{1'b1, 6'b100000, 3'b001, 3'b000, 6'b000001, 3'b100},
      '{1'b0, 6'b000000, 3'b100, 3'b000, 6'b100001, 3'b000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = 1'b0; wr_data = '0; done = '0; ack = '0;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", stat, 32'h0);
      chk("R1 req", {29'b0, fq, wq, tq}, 32'h0);
      chk("R1 en", {29'b0, en}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         wr_en = VECS[i].we;
         wr_data = {2'b00, VECS[i].wd, 24'h0};
         done = VECS[i].dn;
         ack = VECS[i].ak;
         @(negedge clk);
         idle();
         chk($sformatf("R2 row%0d status", i + 1), {26'b0, stat[29:24]}, {26'b0, VECS[i].es});
         chk($sformatf("R7 row%0d req", i + 1), {29'b0, fq, wq, tq}, {29'b0, VECS[i].er});
         // R11 reduced instance sees the same stimulus
         chk($sformatf("R11 row%0d lite status", i + 1), {26'b0, stat_l[29:24]},
             {26'b0, 3'b000, VECS[i].es[2:0]});
         chk($sformatf("R11 row%0d lite req", i + 1), {29'b0, fq_l, wq_l, tq_l},
             {29'b0, 2'b00, VECS[i].er[0]});
      end

      // R2 whole word: only bits 29 and 24 set
      @(negedge clk);
      chk("R2 full word", stat, 32'h2100_0000);

      // R6 enable outputs follow the write at once, status waits for ack
      wr_en = 1'b1; wr_data = 32'h1600_0000;
      @(negedge clk);
      idle();
      chk("R6 en driven", {29'b0, en}, 32'h7);
      chk("R6 status waits", stat, 32'h2100_0000);
      chk("R11 lite en masked", {29'b0, en_l}, 32'h3);
      @(negedge clk);
      chk("R6 status still waits", stat, 32'h2100_0000);
      ack = 3'b100;
      @(negedge clk);
      idle();
      chk("R6 afl mirrored", stat, 32'h3100_0000);
      chk("R11 lite afl stays 0", stat_l, 32'h0100_0000);

      // R1 reset in mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset status", stat, 32'h0);
      chk("R1 mid reset en", {29'b0, en}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule